// File: doc/BRIEF.md
# Trap Entry Controller with Double-Trap Detection

This block holds the trap-related machine and supervisor status state of a hart and updates it on trap entry and on the two trap-return strobes. A trap request arrives with an interrupt flag, a cause code, the faulting PC, a trap value and a one-bit target: machine or supervisor. The delegation lookup has already produced that target. The block also takes the privilege the hart is running at. Each event completes in one clock edge. The block then presents the new privilege, a selector for the machine or supervisor vector base, and every status field and trap register it holds.

Two optional safeguards catch a trap taken while the handler at the target level is still in its critical window. Each safeguard has its own static parameter. At supervisor level, a trap that arrives while the supervisor critical bit is set is redirected to machine level. This happens only when the double-trap enable bit is on. The cause that would have been recorded is kept in a second trap-value register. At machine level, a trap that arrives while the machine critical bit is set is not taken at all. Instead the block raises a sticky critical-error flag and freezes until reset.

The double-trap enable bit is written through a simple write strobe. Address decode, vector arithmetic and the delegation lookup stay outside the block.

Top module: `trap_dbl_ctrl`

## Requirements
- R1: After reset, new_priv is machine (3), vec_sel is 0 and crit_err is 0. mdt equals the machine double-trap parameter. sdt, dte, every interrupt-enable field, mpp, spp and every trap register are 0.
- R2: A trap with target machine that is not a machine double trap updates several fields. mcause takes the cause word: bit XLEN-1 is the interrupt flag, bits CAUSE_W-1:0 are the code and all other bits are 0. mepc takes the PC and mtval takes the trap value. mpie takes the old mie, mie clears and mpp takes cur_priv. mdt becomes 1 when the machine feature is enabled. new_priv becomes 3 and vec_sel becomes 0.
- R3: A trap with target supervisor that is not a supervisor double trap updates the supervisor state. scause takes the cause word, sepc takes the PC and stval takes the trap value. spp becomes 1 exactly when cur_priv is 1. spie takes the old sie and sie clears. new_priv becomes 1 and vec_sel becomes 1. sdt becomes 1 when the supervisor feature is enabled and dte is 1.
- R4: A trap with target supervisor while sdt=1 and dte=1 is taken at machine level as in R2, with three differences. mtval2 takes the cause word the trap would have recorded. mcause is 16 with its interrupt bit 0. All supervisor registers and fields are unchanged.
- R5: A trap with target machine while mdt=1 sets crit_err on the next edge and changes no other output.
- R6: Once crit_err is 1 it stays 1 until reset, and trap, MRET and SRET requests change no output.
- R7: MRET sets new_priv to the old mpp, mie to the old mpie, mpie to 1 and mpp to 0. It clears mdt, and it clears sdt only when the old mpp is 0 (user).
- R8: SRET sets new_priv to 1 if the old spp is 1 and to 0 otherwise. It sets sie to the old spie, spie to 1 and spp to 0, and it clears both sdt and mdt.
- R9: When several requests are raised together, a trap wins over MRET and MRET wins over SRET. The losers have no effect.
- R10: dte takes dte_wdata on a cycle with dte_we=1. While dte is 0, a supervisor-target trap never sets sdt and is never redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dte_we | input | 1 | Write strobe for the double-trap enable bit |
| dte_wdata | input | 1 | Value written to the enable bit |
| trap_req | input | 1 | Trap request |
| trap_intr | input | 1 | Trap is an interrupt |
| trap_cause | input | CAUSE_W | Cause code |
| trap_pc | input | XLEN | Faulting PC |
| trap_tval | input | XLEN | Trap value |
| trap_to_s | input | 1 | Delegated target: 1 supervisor, 0 machine |
| mret | input | 1 | Machine return strobe |
| sret | input | 1 | Supervisor return strobe |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| new_priv | output | 2 | Privilege after the last event |
| vec_sel | output | 1 | Vector base selector: 0 machine, 1 supervisor |
| crit_err | output | 1 | Sticky critical-error flag |
| dte | output | 1 | Double-trap enable bit |
| mdt | output | 1 | Machine critical bit |
| sdt | output | 1 | Supervisor critical bit |
| mie | output | 1 | Machine interrupt enable |
| mpie | output | 1 | Previous machine interrupt enable |
| mpp | output | 2 | Previous privilege for machine traps |
| sie | output | 1 | Supervisor interrupt enable |
| spie | output | 1 | Previous supervisor interrupt enable |
| spp | output | 1 | Previous privilege for supervisor traps |
| mcause | output | XLEN | Machine cause register |
| mtval2 | output | XLEN | Second machine trap value |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause register |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |

## Verification
The bench targets the machine critical bit, which is already 1 out of reset, so the very first machine trap must halt. A design that ignored the reset value would take that trap and overwrite mepc. The bench sends a supervisor trap twice, once with the enable bit off and once with it on. A design that skipped the enable would redirect where it should not, and one that skipped mtval2 or the code-16 rewrite would show the wrong cause. It also checks MRET returning to user against MRET returning to supervisor, where a wrong design clears sdt in both cases. Finally it raises requests together and after a halt, where a wrong priority or a non-sticky flag changes the saved state.

// File: rtl/trap_dbl_pkg.sv
package trap_dbl_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  // Privilege reached by a supervisor return
  function automatic logic [1:0] sret_dest(input logic prev_s);
    return prev_s ? PRIV_S : PRIV_U;
  endfunction
endpackage

// File: rtl/trap_dbl_detect.sv
module trap_dbl_detect #(
  parameter bit SDBL_EN = 1'b1
) (
  input  logic trap_req,
  input  logic trap_to_s,
  input  logic mret,
  input  logic sret,
  input  logic crit,
  input  logic mdt,
  input  logic sdt,
  input  logic dte,
  output logic ev_mtrap,
  output logic ev_strap,
  output logic ev_sdbl,
  output logic ev_mdbl,
  output logic ev_mret,
  output logic ev_sret
);
  logic live;
  always_comb begin
    live     = !crit;
    ev_mdbl  = live && trap_req && !trap_to_s && mdt;
    ev_sdbl  = live && trap_req && trap_to_s && SDBL_EN && sdt && dte;
    ev_mtrap = live && trap_req && ((!trap_to_s && !mdt) || ev_sdbl);
    ev_strap = live && trap_req && trap_to_s && !ev_sdbl;
    ev_mret  = live && !trap_req && mret;
    ev_sret  = live && !trap_req && !mret && sret;
  end
endmodule

// File: rtl/trap_status_regs.sv
module trap_status_regs
  import trap_dbl_pkg::*;
#(
  parameter bit MDBL_EN = 1'b1,
  parameter bit SDBL_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dte_we,
  input  logic       dte_wdata,
  input  logic [1:0] cur_priv,
  input  logic       ev_mtrap,
  input  logic       ev_strap,
  input  logic       ev_mdbl,
  input  logic       ev_mret,
  input  logic       ev_sret,
  output logic [1:0] new_priv,
  output logic       vec_sel,
  output logic       crit,
  output logic       dte,
  output logic       mdt,
  output logic       sdt,
  output logic       mie,
  output logic       mpie,
  output logic [1:0] mpp,
  output logic       sie,
  output logic       spie,
  output logic       spp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_priv <= PRIV_M;
      vec_sel  <= 1'b0;
      crit     <= 1'b0;
      dte      <= 1'b0;
      mdt      <= MDBL_EN;
      sdt      <= 1'b0;
      mie      <= 1'b0;
      mpie     <= 1'b0;
      mpp      <= PRIV_U;
      sie      <= 1'b0;
      spie     <= 1'b0;
      spp      <= 1'b0;
    end else begin
      if (dte_we) dte <= dte_wdata;
      if (ev_mdbl) crit <= 1'b1;
      if (ev_mtrap) begin
        new_priv <= PRIV_M;
        vec_sel  <= 1'b0;
        mpie     <= mie;
        mie      <= 1'b0;
        mpp      <= cur_priv;
        if (MDBL_EN) mdt <= 1'b1;
      end else if (ev_strap) begin
        new_priv <= PRIV_S;
        vec_sel  <= 1'b1;
        spie     <= sie;
        sie      <= 1'b0;
        spp      <= (cur_priv == PRIV_S);
        if (SDBL_EN && dte) sdt <= 1'b1;
      end else if (ev_mret) begin
        new_priv <= mpp;
        mie      <= mpie;
        mpie     <= 1'b1;
        mpp      <= PRIV_U;
        mdt      <= 1'b0;
        if (mpp == PRIV_U) sdt <= 1'b0;
      end else if (ev_sret) begin
        new_priv <= sret_dest(spp);
        sie      <= spie;
        spie     <= 1'b1;
        spp      <= 1'b0;
        sdt      <= 1'b0;
        mdt      <= 1'b0;
      end
    end
  end

  a_r2_mtrap_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mtrap |=> new_priv == PRIV_M && !mie && !vec_sel && (mdt || !MDBL_EN));
  a_r5_mdbl_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mdbl |=> crit && $stable(new_priv) && $stable(mpp));
  a_r6_crit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    crit |=> crit && $stable(mdt) && $stable(sdt) && $stable(new_priv));
  a_r7_mret_clears_mdt: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mret |=> !mdt && mpp == PRIV_U);
  a_r8_sret_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sret |=> !sdt && !mdt && !spp);
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_mtrap, ev_strap, ev_mdbl, ev_mret, ev_sret}) <= 1);
endmodule

// File: rtl/trap_cause_regs.sv
module trap_cause_regs #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned DBL_CODE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_intr,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    trap_tval,
  input  logic               ev_mtrap,
  input  logic               ev_strap,
  input  logic               ev_sdbl,
  output logic [XLEN-1:0]    mcause,
  output logic [XLEN-1:0]    mtval2,
  output logic [XLEN-1:0]    mepc,
  output logic [XLEN-1:0]    mtval,
  output logic [XLEN-1:0]    scause,
  output logic [XLEN-1:0]    sepc,
  output logic [XLEN-1:0]    stval
);
  localparam logic [CAUSE_W-1:0] DBL_C = CAUSE_W'(DBL_CODE);

  function automatic logic [XLEN-1:0] cause_word(input logic intr,
                                                 input logic [CAUSE_W-1:0] code);
    logic [XLEN-1:0] w;
    w = '0;
    w[CAUSE_W-1:0] = code;
    w[XLEN-1] = intr;
    return w;
  endfunction

  logic [XLEN-1:0] req_word;
  assign req_word = cause_word(trap_intr, trap_cause);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcause <= '0;
      mtval2 <= '0;
      mepc   <= '0;
      mtval  <= '0;
      scause <= '0;
      sepc   <= '0;
      stval  <= '0;
    end else if (ev_mtrap) begin
      mcause <= ev_sdbl ? cause_word(1'b0, DBL_C) : req_word;
      if (ev_sdbl) mtval2 <= req_word;
      mepc   <= trap_pc;
      mtval  <= trap_tval;
    end else if (ev_strap) begin
      scause <= req_word;
      sepc   <= trap_pc;
      stval  <= trap_tval;
    end
  end

  a_r4_dbl_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sdbl |=> !mcause[XLEN-1] && mcause[CAUSE_W-1:0] == DBL_C && $stable(scause) && $stable(sepc));
  a_r3_strap_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strap |=> $stable(mcause) && $stable(mepc) && $stable(mtval2));
endmodule

// File: rtl/trap_dbl_ctrl.sv
module trap_dbl_ctrl #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned DBL_CODE = 16,
  parameter bit          MDBL_EN  = 1'b1,
  parameter bit          SDBL_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dte_we,
  input  logic               dte_wdata,
  input  logic               trap_req,
  input  logic               trap_intr,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    trap_tval,
  input  logic               trap_to_s,
  input  logic               mret,
  input  logic               sret,
  input  logic [1:0]         cur_priv,
  output logic [1:0]         new_priv,
  output logic               vec_sel,
  output logic               crit_err,
  output logic               dte,
  output logic               mdt,
  output logic               sdt,
  output logic               mie,
  output logic               mpie,
  output logic [1:0]         mpp,
  output logic               sie,
  output logic               spie,
  output logic               spp,
  output logic [XLEN-1:0]    mcause,
  output logic [XLEN-1:0]    mtval2,
  output logic [XLEN-1:0]    mepc,
  output logic [XLEN-1:0]    mtval,
  output logic [XLEN-1:0]    scause,
  output logic [XLEN-1:0]    sepc,
  output logic [XLEN-1:0]    stval
);
  logic ev_mtrap, ev_strap, ev_sdbl, ev_mdbl, ev_mret, ev_sret;

  trap_dbl_detect #(.SDBL_EN(SDBL_EN)) u_detect (
    .trap_req(trap_req), .trap_to_s(trap_to_s), .mret(mret), .sret(sret),
    .crit(crit_err), .mdt(mdt), .sdt(sdt), .dte(dte),
    .ev_mtrap(ev_mtrap), .ev_strap(ev_strap), .ev_sdbl(ev_sdbl),
    .ev_mdbl(ev_mdbl), .ev_mret(ev_mret), .ev_sret(ev_sret)
  );

  trap_status_regs #(.MDBL_EN(MDBL_EN), .SDBL_EN(SDBL_EN)) u_status (
    .clk(clk), .rst_n(rst_n), .dte_we(dte_we), .dte_wdata(dte_wdata),
    .cur_priv(cur_priv), .ev_mtrap(ev_mtrap), .ev_strap(ev_strap),
    .ev_mdbl(ev_mdbl), .ev_mret(ev_mret), .ev_sret(ev_sret),
    .new_priv(new_priv), .vec_sel(vec_sel), .crit(crit_err), .dte(dte),
    .mdt(mdt), .sdt(sdt), .mie(mie), .mpie(mpie), .mpp(mpp),
    .sie(sie), .spie(spie), .spp(spp)
  );

  trap_cause_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .DBL_CODE(DBL_CODE)) u_cause (
    .clk(clk), .rst_n(rst_n), .trap_intr(trap_intr), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .trap_tval(trap_tval), .ev_mtrap(ev_mtrap),
    .ev_strap(ev_strap), .ev_sdbl(ev_sdbl), .mcause(mcause), .mtval2(mtval2),
    .mepc(mepc), .mtval(mtval), .scause(scause), .sepc(sepc), .stval(stval)
  );

  a_r10_no_redirect_without_dte: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && trap_to_s && !dte && !crit_err |=> new_priv == 2'd1 && $stable(mcause));
endmodule

// File: tb/trap_dbl_ctrl_test.sv
`timescale 1ns/1ps
module trap_dbl_ctrl_test;
  localparam int XL = 64;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, dte_we, dte_wdata, trap_req, trap_intr, trap_to_s, mret, sret;
  logic [CW-1:0] trap_cause;
  logic [XL-1:0] trap_pc, trap_tval;
  logic [1:0] cur_priv;
  logic [1:0] new_priv, mpp;
  logic vec_sel, crit_err, dte, mdt, sdt, mie, mpie, sie, spie, spp;
  logic [XL-1:0] mcause, mtval2, mepc, mtval, scause, sepc, stval;

  trap_dbl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dte_we(dte_we), .dte_wdata(dte_wdata),
    .trap_req(trap_req), .trap_intr(trap_intr), .trap_cause(trap_cause),
    .trap_pc(trap_pc), .trap_tval(trap_tval), .trap_to_s(trap_to_s),
    .mret(mret), .sret(sret), .cur_priv(cur_priv), .new_priv(new_priv),
    .vec_sel(vec_sel), .crit_err(crit_err), .dte(dte), .mdt(mdt), .sdt(sdt),
    .mie(mie), .mpie(mpie), .mpp(mpp), .sie(sie), .spie(spie), .spp(spp),
    .mcause(mcause), .mtval2(mtval2), .mepc(mepc), .mtval(mtval),
    .scause(scause), .sepc(sepc), .stval(stval)
  );

  int checks = 0, errors = 0;

  // expected state
  logic [1:0] x_priv, x_mpp;
  logic x_vs, x_crit, x_dte, x_mdt, x_sdt, x_mie, x_mpie, x_sie, x_spie, x_spp;
  logic [XL-1:0] x_mcause, x_mtval2, x_mepc, x_mtval, x_scause, x_sepc, x_stval;

  function automatic logic [XL-1:0] word_of(input logic intr, input logic [CW-1:0] c);
    return ({63'd0, intr} << (XL - 1)) | {58'd0, c};
  endfunction

  task automatic cmp(input string tag, input string nm, input logic [XL-1:0] a, input logic [XL-1:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, a, e);
    end
  endtask

  task automatic cmp_all(input string tag);
    cmp(tag, "new_priv", 64'(new_priv), 64'(x_priv));
    cmp(tag, "vec_sel", 64'(vec_sel), 64'(x_vs));
    cmp(tag, "crit_err", 64'(crit_err), 64'(x_crit));
    cmp(tag, "dte", 64'(dte), 64'(x_dte));
    cmp(tag, "mdt", 64'(mdt), 64'(x_mdt));
    cmp(tag, "sdt", 64'(sdt), 64'(x_sdt));
    cmp(tag, "mie", 64'(mie), 64'(x_mie));
    cmp(tag, "mpie", 64'(mpie), 64'(x_mpie));
    cmp(tag, "mpp", 64'(mpp), 64'(x_mpp));
    cmp(tag, "sie", 64'(sie), 64'(x_sie));
    cmp(tag, "spie", 64'(spie), 64'(x_spie));
    cmp(tag, "spp", 64'(spp), 64'(x_spp));
    cmp(tag, "mcause", mcause, x_mcause);
    cmp(tag, "mtval2", mtval2, x_mtval2);
    cmp(tag, "mepc", mepc, x_mepc);
    cmp(tag, "mtval", mtval, x_mtval);
    cmp(tag, "scause", scause, x_scause);
    cmp(tag, "sepc", sepc, x_sepc);
    cmp(tag, "stval", stval, x_stval);
  endtask

  task automatic idle_inputs();
    dte_we = 0; dte_wdata = 0; trap_req = 0; trap_intr = 0; trap_to_s = 0;
    mret = 0; sret = 0; trap_cause = '0; trap_pc = '0; trap_tval = '0; cur_priv = 2'd3;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    x_priv = 2'd3; x_vs = 0; x_crit = 0; x_dte = 0; x_mdt = 1; x_sdt = 0;
    x_mie = 0; x_mpie = 0; x_mpp = 0; x_sie = 0; x_spie = 0; x_spp = 0;
    x_mcause = 0; x_mtval2 = 0; x_mepc = 0; x_mtval = 0;
    x_scause = 0; x_sepc = 0; x_stval = 0;
    cmp_all("R1");
  endtask

  // Expected-state update from the requirements; returns the tag checked.
  function automatic string predict();
    string tag;
    logic [XL-1:0] w;
    logic [1:0] op;
    w = word_of(trap_intr, trap_cause);
    tag = "R9";
    if (x_crit) tag = "R6";
    else if (trap_req) begin
      if (!trap_to_s && x_mdt) begin
        x_crit = 1; tag = "R5";
      end else if (trap_to_s && !(x_sdt && x_dte)) begin
        x_scause = w; x_sepc = trap_pc; x_stval = trap_tval;
        x_spp = (cur_priv == 2'd1); x_spie = x_sie; x_sie = 0;
        if (x_dte) x_sdt = 1;
        x_priv = 2'd1; x_vs = 1;
        tag = x_dte ? "R3" : "R10";
      end else begin
        if (trap_to_s) begin
          x_mtval2 = w; x_mcause = 64'd16; tag = "R4";
        end else begin
          x_mcause = w; tag = "R2";
        end
        x_mepc = trap_pc; x_mtval = trap_tval;
        x_mpie = x_mie; x_mie = 0; x_mpp = cur_priv; x_mdt = 1;
        x_priv = 2'd3; x_vs = 0;
      end
      if (mret || sret) tag = "R9";
    end else if (mret) begin
      op = x_mpp;
      x_priv = op; x_mie = x_mpie; x_mpie = 1; x_mpp = 0; x_mdt = 0;
      if (op == 2'd0) x_sdt = 0;
      tag = sret ? "R9" : "R7";
    end else if (sret) begin
      x_priv = x_spp ? 2'd1 : 2'd0; x_sie = x_spie; x_spie = 1; x_spp = 0;
      x_sdt = 0; x_mdt = 0; tag = "R8";
    end else tag = "R10";
    if (dte_we) x_dte = dte_wdata;
    return tag;
  endfunction

  task automatic step();
    string tag;
    @(posedge clk);
    @(negedge clk);
    tag = predict();
    cmp_all(tag);
    idle_inputs();
  endtask

  task automatic trap(input logic to_s, input logic intr, input logic [CW-1:0] c,
                      input logic [XL-1:0] pc, input logic [XL-1:0] tv, input logic [1:0] cp);
    trap_req = 1; trap_to_s = to_s; trap_intr = intr; trap_cause = c;
    trap_pc = pc; trap_tval = tv; cur_priv = cp;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    do_reset();
    // R5: mdt is 1 out of reset, so a machine trap halts at once
    trap(0, 0, 6'd2, 64'h1000, 64'hdead, 2'd3);
    // R6: further requests ignored
    trap(1, 1, 6'd5, 64'h2000, 64'h1, 2'd1);
    mret = 1; step();
    do_reset();
    // R7: mret to user clears mdt and sdt
    mret = 1; step();
    // R10: dte off, supervisor trap does not set sdt
    trap(1, 0, 6'd8, 64'h3000, 64'h33, 2'd0);
    trap(1, 0, 6'd9, 64'h3004, 64'h34, 2'd1);
    // R8: sret back to supervisor
    sret = 1; step();
    // R10: write dte
    dte_we = 1; dte_wdata = 1; step();
    // R3: supervisor trap with dte on sets sdt
    trap(1, 1, 6'd5, 64'h4000, 64'h44, 2'd0);
    // R4: second supervisor trap is redirected
    trap(1, 1, 6'd9, 64'h4010, 64'h45, 2'd1);
    // R7: mret to supervisor keeps sdt
    mret = 1; step();
    // R9: trap with mret and sret together
    trap_req = 1; mret = 1; sret = 1; trap_to_s = 0; trap_cause = 6'd3;
    trap_pc = 64'h5000; trap_tval = 64'h55; cur_priv = 2'd1; step();
    // R5 again: machine trap while mdt=1
    trap(0, 0, 6'd11, 64'h6000, 64'h66, 2'd3);
    do_reset();
    mret = 1; sret = 1; step();  // R9 mret over sret
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (x_crit && ($urandom % 4 == 0)) do_reset();
      trap_req  = ($urandom % 10) < 4;
      mret      = ($urandom % 10) < 3;
      sret      = ($urandom % 10) < 3;
      trap_to_s = ($urandom % 3) != 0;
      trap_intr = $urandom % 2;
      trap_cause = 6'($urandom);
      trap_pc   = {$urandom, $urandom};
      trap_tval = {$urandom, $urandom};
      case ($urandom % 3)
        0: cur_priv = 2'd0;
        1: cur_priv = 2'd1;
        default: cur_priv = 2'd3;
      endcase
      dte_we    = ($urandom % 8) == 0;
      dte_wdata = $urandom % 2;
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule